// File: doc/BRIEF.md
# Cache-Line Miss Fill Timing Controller

This block answers a cache refill request by fetching a four-word line from main memory. It reproduces the timing of that fetch cycle by cycle: the address phase, the memory access phase and the transfer phase. It also returns the line's words and counts how many cycles the refill takes. A parameter selects one of three memory organizations.

- **Narrow:** every word goes through its own address, access and transfer phases in turn.
- **Wide:** the whole line moves in one address phase, one access phase and one transfer.
- **Interleaved:** one-word banks all take a single address broadcast and access together. Their words then cross a one-word bus one after another.

A cache controller raises a request with a line address while the block is idle. It then collects the words as they are presented. The done pulse marks the end of the refill. The penalty output gives the refill's total cost for performance accounting. The memory contents are synthetic: each word's value is derived from its own word address, so the returned data can be checked.

Top module: `fill_timing_ctrl`

## Requirements
- R1: During and right after reset, `busy`, `fill_valid` and `fill_done` are 0 and `penalty` is 0.
- R2: A request is taken on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly the refill penalty in cycles, starting in the next cycle, and returns to 0 in the cycle after `fill_done`.
- R3: Narrow organization (address 4, access 56, transfer 4 cycles): `fill_valid` is 1 in fill cycles 64, 128, 192 and 256, and the penalty is 256.
- R4: Wide organization: `fill_valid` is 1 only in fill cycle 64. That single beat carries all four words, with word i in lane i (`fill_data[32*i +: 32]`), and the penalty is 64.
- R5: Interleaved organization: `fill_valid` is 1 in fill cycles 64, 68, 72 and 76, and the penalty is 76.
- R6: Words come out in ascending index order (`fill_idx` is 0 for the wide beat). The data of word i is the 32-bit zero-extended word address {line address, i[1:0]} XOR 32'h5A3C96E1. The word is served by the bank that matches the low two bits of its word address.
- R7: `fill_valid` is 1 for one cycle only, in the last cycle of each transfer phase, and only while `busy` is 1.
- R8: `fill_done` is 1 in the same cycle as the last word's `fill_valid` and in no other cycle.
- R9: In the k-th cycle of a refill, `penalty` reads k. After `fill_done` it holds the total until the next request is taken.
- R10: A request raised while `busy` is 1, including in the `fill_done` cycle, is ignored. The refill's timing and its line address do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request |
| req_blk | input | AW (24) | Line address of the request |
| busy | output | 1 | Refill in progress |
| fill_valid | output | 1 | A transfer beat is presented this cycle |
| fill_idx | output | log2(WORDS) (2) | Index of the first word in the beat |
| fill_data | output | LANES*DW (32, or 128 when wide) | Beat data, with word i in lane i |
| fill_done | output | 1 | Last beat of the refill |
| penalty | output | log2(penalty+1) | Cycles elapsed in the current or last refill |

## Verification
Some properties are checked by the assertions on every cycle:
- beats occur only while busy and are always single-cycle pulses;
- done coincides with the last word's index and with a penalty equal to the organization's total;
- busy drops right after done;
- the captured line address stays stable while later requests arrive;
- the penalty stays put while the block is idle.

Other behaviour only the bench's scenarios can show. This covers the exact fill cycle of each beat in all three organizations and the ascending word order. It also covers each word's data as drawn from the correct bank. Finally, it covers that back-to-back and overlapping requests are taken or dropped at the right edge.

// File: rtl/fill_pkg.sv
package fill_pkg;

   typedef enum logic [1:0] {
      ORG_NARROW      = 2'd0,
      ORG_WIDE        = 2'd1,
      ORG_INTERLEAVED = 2'd2
   } mem_org_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACCESS,
      PH_XFER
   } phase_e;

   // number of bus transfers needed to move one line
   function automatic int fill_beats(mem_org_e org, int words);
      return (org == ORG_WIDE) ? 1 : words;
   endfunction

   // total refill cost in cycles for a given organization
   function automatic int fill_penalty(mem_org_e org, int words, int a, int c, int x);
      case (org)
         ORG_NARROW: return words * (a + c + x);
         ORG_WIDE:   return a + c + x;
         default:    return a + c + words * x;
      endcase
   endfunction

endpackage

// File: rtl/fill_seq.sv
module fill_seq
   import fill_pkg::*;
#(
   parameter mem_org_e ORG      = ORG_INTERLEAVED,
   parameter int       WORDS    = 4,
   parameter int       ADDR_CYC = 4,
   parameter int       ACC_CYC  = 56,
   parameter int       XFER_CYC = 4,
   localparam int      IW       = $clog2(WORDS),
   localparam int      PENALTY  = fill_penalty(ORG, WORDS, ADDR_CYC, ACC_CYC, XFER_CYC),
   localparam int      PW       = $clog2(PENALTY + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          acc_end,
   output logic          xfer_end,
   output logic          last_beat,
   output logic [IW-1:0] beat,
   output logic [PW-1:0] penalty
);

   localparam int BEATS = fill_beats(ORG, WORDS);
   localparam int MAX_AC = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC;
   localparam int MAXP   = (MAX_AC > XFER_CYC) ? MAX_AC : XFER_CYC;
   localparam int CW     = $clog2(MAXP);
   localparam logic [CW-1:0] LD_A = CW'(ADDR_CYC - 1);
   localparam logic [CW-1:0] LD_C = CW'(ACC_CYC - 1);
   localparam logic [CW-1:0] LD_X = CW'(XFER_CYC - 1);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("fill_seq: WORDS must be a power of two, at least 2");
   end
   if (ADDR_CYC < 1 || ACC_CYC < 1 || XFER_CYC < 2) begin : g_bad_cycles
      $error("fill_seq: phase lengths out of range");
   end

   phase_e        phase;
   logic [CW-1:0] pcnt;
   logic [PW-1:0] cnt;
   logic          phase_end;
   phase_e        after_beat;
   logic [CW-1:0] after_load;

   // what follows a non-final transfer depends on the organization
   if (ORG == ORG_NARROW) begin : g_refetch
      assign after_beat = PH_ADDR;
      assign after_load = LD_A;
   end else begin : g_stream
      assign after_beat = PH_XFER;
      assign after_load = LD_X;
   end

   assign phase_end = (pcnt == '0);
   assign busy      = (phase != PH_IDLE);
   assign acc_end   = (phase == PH_ACCESS) && phase_end;
   assign xfer_end  = (phase == PH_XFER) && phase_end;
   assign last_beat = (beat == IW'(BEATS - 1));
   assign penalty   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         pcnt  <= '0;
         beat  <= '0;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_ADDR;
                  pcnt  <= LD_A;
                  beat  <= '0;
                  cnt   <= PW'(1);
               end
            end
            PH_ADDR: begin
               cnt <= cnt + PW'(1);
               if (phase_end) begin
                  phase <= PH_ACCESS;
                  pcnt  <= LD_C;
               end else begin
                  pcnt <= pcnt - CW'(1);
               end
            end
            PH_ACCESS: begin
               cnt <= cnt + PW'(1);
               if (phase_end) begin
                  phase <= PH_XFER;
                  pcnt  <= LD_X;
               end else begin
                  pcnt <= pcnt - CW'(1);
               end
            end
            PH_XFER: begin
               if (phase_end) begin
                  if (last_beat) begin
                     phase <= PH_IDLE;
                  end else begin
                     cnt   <= cnt + PW'(1);
                     phase <= after_beat;
                     pcnt  <= after_load;
                     beat  <= beat + IW'(1);
                  end
               end else begin
                  cnt  <= cnt + PW'(1);
                  pcnt <= pcnt - CW'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R9: the running count never passes the organization's total
   assert_penalty_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (penalty != '0) && (penalty <= PW'(PENALTY)));

   // R6: the beat index never exceeds the last beat
   assert_beat_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      beat <= IW'(BEATS - 1));

endmodule

// File: rtl/fill_bank.sv
module fill_bank #(
   parameter int            BANK  = 0,
   parameter int            WORDS = 4,
   parameter int            AW    = 24,
   parameter int            DW    = 32,
   parameter logic [DW-1:0] SALT  = '0,
   localparam int           IW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic [AW-1:0] blk,
   output logic [DW-1:0] word
);

   // the low bits of the word address name this bank
   logic [AW+IW-1:0] waddr;
   assign waddr = {blk, IW'(BANK)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (cap) begin
         word <= DW'(waddr) ^ SALT;
      end
   end

endmodule

// File: rtl/fill_timing_ctrl.sv
module fill_timing_ctrl
   import fill_pkg::*;
#(
   parameter mem_org_e      ORG      = ORG_INTERLEAVED,
   parameter int            WORDS    = 4,
   parameter int            ADDR_CYC = 4,
   parameter int            ACC_CYC  = 56,
   parameter int            XFER_CYC = 4,
   parameter int            AW       = 24,
   parameter int            DW       = 32,
   parameter logic [DW-1:0] SALT     = DW'(32'h5A3C_96E1),
   localparam int           IW       = $clog2(WORDS),
   localparam int           LANES    = (ORG == ORG_WIDE) ? WORDS : 1,
   localparam int           PENALTY  = fill_penalty(ORG, WORDS, ADDR_CYC, ACC_CYC, XFER_CYC),
   localparam int           PW       = $clog2(PENALTY + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [AW-1:0]       req_blk,
   output logic                busy,
   output logic                fill_valid,
   output logic [IW-1:0]       fill_idx,
   output logic [LANES*DW-1:0] fill_data,
   output logic                fill_done,
   output logic [PW-1:0]       penalty
);

   localparam int LAST_IDX = (LANES == 1) ? WORDS - 1 : 0;

   if (DW < AW + IW) begin : g_bad_width
      $error("fill_timing_ctrl: DW must hold a full word address");
   end

   logic          accept;
   logic [AW-1:0] blk_q;
   logic          acc_end;
   logic          xfer_end;
   logic          last_beat;
   logic [IW-1:0] beat;
   logic [DW-1:0] bank_word [WORDS];

   assign accept = req_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q <= '0;
      end else if (accept) begin
         blk_q <= req_blk;
      end
   end

   fill_seq #(
      .ORG(ORG), .WORDS(WORDS), .ADDR_CYC(ADDR_CYC),
      .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy),
      .acc_end(acc_end), .xfer_end(xfer_end), .last_beat(last_beat),
      .beat(beat), .penalty(penalty)
   );

   for (genvar g = 0; g < WORDS; g++) begin : g_bank
      logic cap;
      // narrow memory reads one bank per access; the others read all at once
      assign cap = acc_end && ((ORG != ORG_NARROW) || (beat == IW'(g)));
      fill_bank #(
         .BANK(g), .WORDS(WORDS), .AW(AW), .DW(DW), .SALT(SALT)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .cap(cap), .blk(blk_q), .word(bank_word[g])
      );
   end

   if (ORG == ORG_WIDE) begin : g_whole_line
      for (genvar l = 0; l < WORDS; l++) begin : g_lane
         assign fill_data[l*DW +: DW] = bank_word[l];
      end
      assign fill_idx = '0;
   end else begin : g_one_word
      assign fill_data = bank_word[beat];
      assign fill_idx  = beat;
   end

   assign fill_valid = xfer_end;
   assign fill_done  = xfer_end && last_beat;

   assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> busy);

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> !fill_valid);

   assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> fill_valid && (fill_idx == IW'(LAST_IDX)));

   assert_done_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (penalty == PW'(PENALTY)));

   assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !busy);

   assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(blk_q));

   assert_penalty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> $stable(penalty));

endmodule

// File: tb/fill_timing_ctrl_test.sv
module fill_timing_ctrl_test;
   import fill_pkg::*;

   localparam int A = 4, C = 56, X = 4, W = 4;
   localparam logic [31:0] SALT = 32'h5A3C_96E1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [23:0] req_blk = '0;

   always #4 clk = ~clk;  // 125 MHz

   logic busy_i, vld_i, done_i;  logic [1:0] idx_i;  logic [31:0]  data_i;  logic [6:0] pen_i;
   logic busy_n, vld_n, done_n;  logic [1:0] idx_n;  logic [31:0]  data_n;  logic [8:0] pen_n;
   logic busy_w, vld_w, done_w;  logic [1:0] idx_w;  logic [127:0] data_w;  logic [6:0] pen_w;

   fill_timing_ctrl #(.ORG(ORG_INTERLEAVED)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
      .busy(busy_i), .fill_valid(vld_i), .fill_idx(idx_i), .fill_data(data_i),
      .fill_done(done_i), .penalty(pen_i));

   fill_timing_ctrl #(.ORG(ORG_NARROW)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
      .busy(busy_n), .fill_valid(vld_n), .fill_idx(idx_n), .fill_data(data_n),
      .fill_done(done_n), .penalty(pen_n));

   fill_timing_ctrl #(.ORG(ORG_WIDE)) uut_wide (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
      .busy(busy_w), .fill_valid(vld_w), .fill_idx(idx_w), .fill_data(data_w),
      .fill_done(done_w), .penalty(pen_w));

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // reference model, index 0 narrow, 1 wide, 2 interleaved
   bit          mb    [3];
   int          mt    [3];
   int          mlast [3];
   logic [23:0] ma    [3];

   function automatic int pen_of(int o);
      if (o == 0) return W * (A + C + X);
      if (o == 1) return A + C + X;
      return A + C + W * X;
   endfunction

   function automatic int beat_at(int o, int t);
      if (o == 0) return (t % (A + C + X) == 0) ? t / (A + C + X) - 1 : -1;
      if (o == 1) return (t == A + C + X) ? 0 : -1;
      return (t >= A + C + X && (t - A - C) % X == 0) ? (t - A - C) / X - 1 : -1;
   endfunction

   function automatic logic [31:0] wval(logic [23:0] a, int i);
      logic [1:0] lo;
      lo = i[1:0];
      return {6'b0, a, lo} ^ SALT;
   endfunction

   task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic observe(int o, bit busy, bit vld, int idx, logic [127:0] data, bit done, int pen);
      int b;
      string t;
      logic [127:0] ed;
      b = mb[o] ? beat_at(o, mt[o]) : -1;
      t = (o == 0) ? "R3" : (o == 1) ? "R4" : "R5";
      check(busy == mb[o], (req_valid && mb[o]) ? "R10 busy" : "R2 busy", busy, mb[o]);
      check(vld == (b >= 0), {t, " R7 word-valid"}, vld, b >= 0);
      check(done == (b >= 0 && b == ((o == 1) ? 0 : W - 1)), "R8 done", done, b);
      check(pen == (mb[o] ? mt[o] : mlast[o]), "R9 penalty", pen, mb[o] ? mt[o] : mlast[o]);
      if (b >= 0) begin
         if (o == 1) ed = {wval(ma[o], 3), wval(ma[o], 2), wval(ma[o], 1), wval(ma[o], 0)};
         else        ed = 128'(wval(ma[o], b));
         check(idx == ((o == 1) ? 0 : b), "R6 index", idx, (o == 1) ? 0 : b);
         check(data == ed, req_valid ? "R6 R10 data" : "R6 data", data, ed);
      end
      if (mb[o] && mt[o] == pen_of(o))
         check(done && pen == pen_of(o), {t, " total penalty"}, pen, pen_of(o));
   endtask

   task automatic step(int o);
      if (mb[o]) begin
         if (mt[o] == pen_of(o)) begin
            mb[o] = 1'b0;
            mlast[o] = mt[o];
         end else begin
            mt[o]++;
         end
      end else if (req_valid) begin
         mb[o] = 1'b1;
         mt[o] = 1;
         ma[o] = req_blk;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         observe(0, busy_n, vld_n, idx_n, 128'(data_n), done_n, pen_n);
         observe(1, busy_w, vld_w, idx_w, data_w,        done_w, pen_w);
         observe(2, busy_i, vld_i, idx_i, 128'(data_i), done_i, pen_i);
         step(0); step(1); step(2);
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog R2: actual %0d expected below %0d cycles", cyc, 150000);
         finish_run();
      end
   end

   task automatic drive(bit v, logic [23:0] a, int n);
      repeat (n) begin
         @(posedge clk);
         #1;
         req_valid = v;
         req_blk   = a;
      end
   endtask

   initial begin
      void'($urandom(32'd715));
      for (int k = 0; k < 3; k++) begin
         mb[k] = 1'b0; mt[k] = 0; mlast[k] = 0; ma[k] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state on every organization
      check(!busy_i && !busy_n && !busy_w, "R1 busy", {busy_n, busy_w, busy_i}, 0);
      check(!vld_i && !vld_n && !vld_w && !done_i && !done_n && !done_w,
            "R1 valid/done", {vld_n, vld_w, vld_i, done_n, done_w, done_i}, 0);
      check(pen_i == 0 && pen_n == 0 && pen_w == 0, "R1 penalty", {pen_n, pen_w, pen_i}, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!busy_i && pen_n == 0, "R1 after reset", {busy_i, pen_n}, 0);

      // directed: lowest and highest line addresses, single-cycle request
      drive(1'b1, 24'h000000, 1);
      drive(1'b0, 24'h000000, 300);
      drive(1'b1, 24'hFFFFFF, 1);
      drive(1'b0, 24'hFFFFFF, 300);

      // R10: request held high with a new address every cycle
      for (int k = 0; k < 700; k++) drive(1'b1, 24'($urandom), 1);
      drive(1'b0, 24'h0, 300);

      // constrained random refills with random hold and gap
      for (int k = 0; k < 30; k++) begin
         drive(1'b1, 24'($urandom), 1 + int'($urandom_range(0, 3)));
         drive(1'b0, 24'h0, int'($urandom_range(0, 120)));
      end
      drive(1'b0, 24'h0, 300);
      finish_run();
   end

endmodule